// File: doc/BRIEF.md
# External memory address router

This block decides where each memory access of an 8-bit controller core lands. A code fetch goes either to on-chip program storage or to the off-chip bus. The choice depends on the fetch address and on an external-access strap pin. When the lock option is programmed, the strap value is captured while reset is asserted and the live pin is ignored from then on. Without the lock option, the live pin is used on every fetch.

For external data moves, the block builds the full off-chip address. The high byte comes from the 16-bit data pointer or from the port-2 output latch, depending on the addressing form. For on-chip data addresses, it tells apart special-register access from access to the upper RAM bank in the 80H–FFH range.

All routing outputs are combinational from the inputs and the captured strap. The only storage is the captured strap bit.

Top module: `mem_route`

## Requirements
- R1: When the effective strap is 0, `fetch_ext` is 1 for every fetch address from 0000H to FFFFH.
- R2: When the effective strap is 1, `fetch_ext` is 0 for addresses below INT_CODE_BYTES (default 2000H, so 0000H–1FFFH) and 1 from 2000H to FFFFH.
- R3: When `lock_prog` is 1, the effective strap is the value `ea_pin` had at the last rising clock edge with `rst_n` low. Later changes of `ea_pin` have no effect on `fetch_ext`.
- R4: When `lock_prog` is 0, the effective strap is the live `ea_pin`, re-evaluated on every fetch.
- R5: When `movx_wide` is 1 (pointer form), `xdata_addr` equals `dptr`.
- R6: When `movx_wide` is 0 (register-indirect form), `xdata_addr[15:8]` equals `p2_latch` and `xdata_addr[7:0]` equals `ri_addr`. The high byte follows every change of `p2_latch`.
- R7: `sfr_sel` is 1 exactly when `dmem_addr[7]` is 1 and `dmem_indirect` is 0 (direct access).
- R8: `hiram_sel` is 1 exactly when `dmem_addr[7]` is 1 and `dmem_indirect` is 1 (indirect access).
- R9: For `dmem_addr` below 80H, both `sfr_sel` and `hiram_sel` are 0. The two selects are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the strap is captured while it is low |
| ea_pin | input | 1 | External-access strap pin (1 = internal code allowed) |
| lock_prog | input | 1 | Lock option programmed (1 = strap captured at reset) |
| fetch_addr | input | 16 | Code fetch address |
| movx_wide | input | 1 | 1 = pointer-form data move, 0 = register-indirect form |
| dptr | input | 16 | Data pointer value |
| p2_latch | input | 8 | Port-2 output latch contents |
| ri_addr | input | 8 | Low address byte from the indirect register |
| dmem_addr | input | 8 | On-chip data address |
| dmem_indirect | input | 1 | 1 = indirect access, 0 = direct access |
| fetch_ext | output | 1 | 1 = fetch goes off-chip, 0 = internal storage |
| xdata_addr | output | 16 | Off-chip data address |
| sfr_sel | output | 1 | Special-register space selected |
| hiram_sel | output | 1 | Upper RAM bank selected |

## Verification
The assertions assume that every input is at a known level at each rising edge. They also assume that `lock_prog` changes only while reset is asserted, since the capture rule is only defined for a fixed lock setting. The stimulus changes inputs only between edges and reprograms the lock option only inside a reset pulse. With the lock on, it drives the strap pin to the opposite level after release, so a design that ignores the captured value would show up.

// File: rtl/mr_pkg.sv
package mr_pkg;
  // Code fetch lands in internal storage when below the internal size.
  function automatic logic code_internal(input logic [31:0] addr,
                                         input logic [31:0] int_bytes);
    return addr < int_bytes;
  endfunction

  // Off-chip data address high byte: pointer form or port latch.
  function automatic logic [7:0] xhi_pick(input logic wide,
                                          input logic [7:0] ptr_hi,
                                          input logic [7:0] latch);
    return wide ? ptr_hi : latch;
  endfunction
endpackage

// File: rtl/mr_strap.sv
module mr_strap (
  input  logic clk,
  input  logic rst_n,
  input  logic ea_pin,
  input  logic lock_prog,
  output logic strap_held,
  output logic strap_eff
);
  always_ff @(posedge clk) begin
    if (!rst_n) strap_held <= ea_pin;
  end

  assign strap_eff = lock_prog ? strap_held : ea_pin;
endmodule

// File: rtl/mr_code_steer.sv
module mr_code_steer #(
  parameter int ADDR_W = 16,
  parameter int INT_CODE_BYTES = 8192
) (
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              strap_eff,
  output logic              fetch_ext
);
  import mr_pkg::*;
  logic in_int_range;
  assign in_int_range = code_internal(32'(fetch_addr), 32'(INT_CODE_BYTES));
  assign fetch_ext = !(strap_eff && in_int_range);
endmodule

// File: rtl/mr_xaddr.sv
module mr_xaddr #(
  parameter int ADDR_W = 16
) (
  input  logic              movx_wide,
  input  logic [ADDR_W-1:0] dptr,
  input  logic [ADDR_W/2-1:0] p2_latch,
  input  logic [ADDR_W/2-1:0] ri_addr,
  output logic [ADDR_W-1:0] xdata_addr
);
  import mr_pkg::*;
  localparam int HALF_W = ADDR_W / 2;
  logic [HALF_W-1:0] hi, lo;
  assign hi = HALF_W'(xhi_pick(movx_wide, 8'(dptr[ADDR_W-1:HALF_W]), 8'(p2_latch)));
  assign lo = movx_wide ? dptr[HALF_W-1:0] : ri_addr;
  assign xdata_addr = {hi, lo};
endmodule

// File: rtl/mr_dspace.sv
module mr_dspace #(
  parameter int DADDR_W = 8
) (
  input  logic [DADDR_W-1:0] dmem_addr,
  input  logic               dmem_indirect,
  output logic               sfr_sel,
  output logic               hiram_sel
);
  logic upper_half;
  assign upper_half = dmem_addr[DADDR_W-1];
  assign sfr_sel    = upper_half && !dmem_indirect;
  assign hiram_sel  = upper_half &&  dmem_indirect;
endmodule

// File: rtl/mem_route.sv
module mem_route #(
  parameter int ADDR_W = 16,
  parameter int INT_CODE_BYTES = 8192,
  parameter int DADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ea_pin,
  input  logic              lock_prog,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              movx_wide,
  input  logic [ADDR_W-1:0] dptr,
  input  logic [ADDR_W/2-1:0] p2_latch,
  input  logic [ADDR_W/2-1:0] ri_addr,
  input  logic [DADDR_W-1:0] dmem_addr,
  input  logic              dmem_indirect,
  output logic              fetch_ext,
  output logic [ADDR_W-1:0] xdata_addr,
  output logic              sfr_sel,
  output logic              hiram_sel
);
  logic strap_held;
  logic strap_eff;

  mr_strap u_strap (
    .clk(clk), .rst_n(rst_n), .ea_pin(ea_pin), .lock_prog(lock_prog),
    .strap_held(strap_held), .strap_eff(strap_eff)
  );

  mr_code_steer #(.ADDR_W(ADDR_W), .INT_CODE_BYTES(INT_CODE_BYTES)) u_code (
    .fetch_addr(fetch_addr), .strap_eff(strap_eff), .fetch_ext(fetch_ext)
  );

  mr_xaddr #(.ADDR_W(ADDR_W)) u_xaddr (
    .movx_wide(movx_wide), .dptr(dptr), .p2_latch(p2_latch),
    .ri_addr(ri_addr), .xdata_addr(xdata_addr)
  );

  mr_dspace #(.DADDR_W(DADDR_W)) u_dspace (
    .dmem_addr(dmem_addr), .dmem_indirect(dmem_indirect),
    .sfr_sel(sfr_sel), .hiram_sel(hiram_sel)
  );
endmodule

// File: rtl/mem_route_chk.sv
module mem_route_chk #(
  parameter int ADDR_W = 16,
  parameter int INT_CODE_BYTES = 8192,
  parameter int DADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ea_pin,
  input logic              lock_prog,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              movx_wide,
  input logic [ADDR_W-1:0] dptr,
  input logic [ADDR_W/2-1:0] p2_latch,
  input logic [ADDR_W/2-1:0] ri_addr,
  input logic [DADDR_W-1:0] dmem_addr,
  input logic              dmem_indirect,
  input logic              fetch_ext,
  input logic [ADDR_W-1:0] xdata_addr,
  input logic              sfr_sel,
  input logic              hiram_sel,
  input logic              strap_held,
  input logic              strap_eff
);
  localparam int HALF_W = ADDR_W / 2;

  assert_strap_low_ext_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_eff |-> fetch_ext);
  assert_int_below_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_eff && (32'(fetch_addr) < INT_CODE_BYTES)) |-> !fetch_ext);
  assert_ext_above_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(fetch_addr) >= INT_CODE_BYTES) |-> fetch_ext);
  assert_held_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(strap_held));
  assert_locked_uses_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_prog |-> (strap_eff == strap_held));
  assert_live_pin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_prog |-> (strap_eff == ea_pin));
  assert_wide_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    movx_wide |-> (xdata_addr == dptr));
  assert_narrow_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !movx_wide |-> (xdata_addr == {p2_latch, ri_addr}));
  assert_direct_sfr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dmem_addr[DADDR_W-1] && !dmem_indirect) |-> sfr_sel);
  assert_indirect_ram_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dmem_addr[DADDR_W-1] && dmem_indirect) |-> hiram_sel);
  assert_low_none_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dmem_addr[DADDR_W-1] |-> !(sfr_sel || hiram_sel));
  assert_sel_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sfr_sel, hiram_sel}));

  logic unused_ok;
  assign unused_ok = ^{xdata_addr[HALF_W-1:0]};
endmodule

bind mem_route mem_route_chk #(
  .ADDR_W(ADDR_W), .INT_CODE_BYTES(INT_CODE_BYTES), .DADDR_W(DADDR_W)
) u_chk (.*);

// File: tb/mem_route_test.sv
module mem_route_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ea_pin = 1'b1;
  logic        lock_prog = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic        movx_wide = 1'b0;
  logic [15:0] dptr = '0;
  logic [7:0]  p2_latch = '0;
  logic [7:0]  ri_addr = '0;
  logic [7:0]  dmem_addr = '0;
  logic        dmem_indirect = 1'b0;
  logic        fetch_ext;
  logic [15:0] xdata_addr;
  logic        sfr_sel, hiram_sel;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mem_route uut (
    .clk(clk), .rst_n(rst_n), .ea_pin(ea_pin), .lock_prog(lock_prog),
    .fetch_addr(fetch_addr), .movx_wide(movx_wide), .dptr(dptr),
    .p2_latch(p2_latch), .ri_addr(ri_addr), .dmem_addr(dmem_addr),
    .dmem_indirect(dmem_indirect), .fetch_ext(fetch_ext),
    .xdata_addr(xdata_addr), .sfr_sel(sfr_sel), .hiram_sel(hiram_sel)
  );

  // Vector layout: {strap, fetch address, expected fetch_ext}
  localparam int NV = 10;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 16'h0000, 1'b1}, {1'b0, 16'h1FFF, 1'b1}, {1'b0, 16'h2000, 1'b1},
    {1'b0, 16'hFFFF, 1'b1}, {1'b1, 16'h0000, 1'b0}, {1'b1, 16'h1FFF, 1'b0},
    {1'b1, 16'h2000, 1'b1}, {1'b1, 16'hFFFF, 1'b1}, {1'b1, 16'h1000, 1'b0},
    {1'b0, 16'h1000, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk); #2;
  endtask

  task automatic do_reset(input logic pin, input logic lock);
    @(negedge clk);
    rst_n = 1'b0; ea_pin = pin; lock_prog = lock;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset(1'b1, 1'b0);
    settle();
    // reset state: unlocked, strap high, address 0 -> internal (R2), below 80H -> no select (R9)
    chk("R2 reset state", 16'(fetch_ext), 16'h0);
    chk("R9 reset state", 16'({sfr_sel, hiram_sel}), 16'h0);

    // R1/R2/R4 vector walk, unlocked: live pin decides
    for (int i = 0; i < NV; i++) begin
      ea_pin = VEC[i][17];
      fetch_addr = VEC[i][16:1];
      settle();
      chk(VEC[i][17] ? "R2 R4 range split" : "R1 R4 strap low", 16'(fetch_ext), 16'(VEC[i][0]));
    end

    // R3: locked, strap captured high then pin pulled low
    do_reset(1'b1, 1'b1);
    ea_pin = 1'b0; fetch_addr = 16'h1FFF;
    settle();
    chk("R3 locked high 1FFF", 16'(fetch_ext), 16'h0);
    fetch_addr = 16'h2000; settle();
    chk("R3 locked high 2000", 16'(fetch_ext), 16'h1);
    repeat (5) @(negedge clk);
    ea_pin = 1'b0; fetch_addr = 16'h0000; settle();
    chk("R3 locked high later", 16'(fetch_ext), 16'h0);

    // R3: locked, strap captured low then pin driven high
    do_reset(1'b0, 1'b1);
    ea_pin = 1'b1; fetch_addr = 16'h0000;
    settle();
    chk("R3 locked low 0000", 16'(fetch_ext), 16'h1);
    fetch_addr = 16'h1FFF; settle();
    chk("R3 locked low 1FFF", 16'(fetch_ext), 16'h1);

    // R4: unlocked again, pin toggling is followed at once
    do_reset(1'b0, 1'b0);
    ea_pin = 1'b1; fetch_addr = 16'h0100; settle();
    chk("R4 live high", 16'(fetch_ext), 16'h0);
    ea_pin = 1'b0; settle();
    chk("R4 live low", 16'(fetch_ext), 16'h1);

    // R5: pointer form
    movx_wide = 1'b1; dptr = 16'hA53C; p2_latch = 8'h7E; ri_addr = 8'h11; settle();
    chk("R5 pointer addr", xdata_addr, 16'hA53C);
    // R6: register-indirect form
    movx_wide = 1'b0; settle();
    chk("R6 latch addr", xdata_addr, 16'h7E11);
    p2_latch = 8'h42; ri_addr = 8'hF0; settle();
    chk("R6 latch follows", xdata_addr, 16'h42F0);

    // R7/R8/R9 data space decode
    dmem_addr = 8'h80; dmem_indirect = 1'b0; settle();
    chk("R7 direct 80", 16'({sfr_sel, hiram_sel}), 16'h2);
    dmem_addr = 8'hFF; dmem_indirect = 1'b1; settle();
    chk("R8 indirect FF", 16'({sfr_sel, hiram_sel}), 16'h1);
    dmem_addr = 8'h80; dmem_indirect = 1'b1; settle();
    chk("R8 indirect 80", 16'({sfr_sel, hiram_sel}), 16'h1);
    dmem_addr = 8'h7F; dmem_indirect = 1'b1; settle();
    chk("R9 indirect 7F", 16'({sfr_sel, hiram_sel}), 16'h0);
    dmem_addr = 8'h7F; dmem_indirect = 1'b0; settle();
    chk("R9 direct 7F", 16'({sfr_sel, hiram_sel}), 16'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule